// File: doc/BRIEF.md
# Paddle Capture-Compare Timer

This block is a free-running 16-bit timebase for a small controller that imitates analog paddle (potentiometer) inputs to a host. The host measures how long each paddle line takes to charge. The block has one capture input, wired to the host's discharge line, and two compare channels whose outputs emulate the paddle lines going high.

A falling edge on the capture input takes a snapshot of the counter but leaves the counter running. Software reads the live count, subtracts the snapshot and adds a fixed offset. It writes the result back into the counter, which re-aligns the timebase to the edge exactly, however late the interrupt was serviced. Software then only programs compare values. A match drives the matching output high, and a software clear bit drives it low again. Because the counter is never cleared by hardware, the difference between two successive snapshots is the host's measurement period expressed in local clocks.

The processor reaches the block through an 8-bit register bus. All 16-bit registers share one temporary byte, so a 16-bit value is read or written atomically.

Top module: `paddle_timer`

## Requirements
- R1: While reset is asserted, the counter, capture register, flags (address 8), enables (address 9), compare outputs (readable at address 10) and `irq` all read as zero.
- R2: The counter advances by one on every clock. When it steps from 0xFFFF to 0x0000 it sets overflow flag bit 3.
- R3: A write to address 1 stores the byte in the temporary register. A write to address 0 then loads the counter with {temporary, written byte} on that clock, and this load takes precedence over the increment.
- R4: If `cap_in` is sampled low at edge k after being sampled high at edge k-1, the capture register (low byte at address 2) is loaded at edge k+2 with the count held just before that edge, and flag bit 0 is set. The counter is not disturbed.
- R5: With the counter left untouched, two captures from falling edges spaced P clocks apart differ by exactly P.
- R6: A read of an even address 0, 2, 4 or 6 returns that register's low byte and copies its high byte into the shared temporary byte. A read of any odd address from 1 to 7 returns the temporary byte.
- R7: Compare registers A and B take their low byte at address 4 or 6, committed with the temporary byte. On the clock after the counter equals a compare value, `cmp_out[0]` or `cmp_out[1]` goes high, and flag bit 1 (A) or bit 2 (B) is set. A compare value the counter has already passed does nothing until the counter reaches it again.
- R8: Writing 1 to bit 0 or bit 1 at address 10 drives `cmp_out[0]` or `cmp_out[1]` low. If the clear and a match fall on the same clock, the clear wins.
- R9: Writing 1 to a bit at address 8 clears that flag. Other flags are left as they were, and a flag set on the same clock stays set.
- R10: `irq` is high exactly when some flag bit is set together with the same bit at address 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Host discharge line; a falling edge triggers a capture |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (takes effect in the temporary byte) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| cmp_out | output | 2 | Emulated paddle outputs, channels A and B |
| irq | output | 1 | Interrupt request |

## Verification
Captures are exercised in three ways. A single edge is issued in step with a counter read, which pins down the exact synchronizer latency and shows that the counter keeps running afterwards. A train of edges with a fixed spacing shows that the period falls out of successive captures. A capture with only its enable set shows that the interrupt follows the flag. Compare matching is tried with a value ahead of the counter, a value the counter has already passed, and a clear timed onto the very match cycle, which separates correct priority from a plain set/reset. Wrap-around is driven from a loaded value near the top of the range, and it also causes an incidental zero match that the flag-clearing test relies on.

// File: rtl/paddle_timer.sv
module paddle_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_in,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [1:0] cmp_out,
  output logic       irq
);

  logic [2:0]  sync_q;
  logic [15:0] cnt, cap, cmp_a, cmp_b;
  logic [7:0]  tmp, hi_sel;
  logic [3:0]  flags, ien, flag_set, w1c;
  logic [1:0]  match, clr, out_q;
  logic        cap_fall, cnt_wr, hi_wr, lo_rd;

  assign cap_fall = sync_q[2] & ~sync_q[1];
  assign cnt_wr   = bus_wr && bus_addr == 4'd0;
  assign hi_wr    = bus_wr && !bus_addr[3] && bus_addr[0];
  assign lo_rd    = bus_rd && !bus_addr[3] && !bus_addr[0];
  assign match    = {cnt == cmp_b, cnt == cmp_a};
  assign clr      = (bus_wr && bus_addr == 4'd10) ? bus_wdata[1:0] : 2'b00;
  assign w1c      = (bus_wr && bus_addr == 4'd8) ? bus_wdata[3:0] : 4'b0000;
  assign flag_set = {cnt == 16'hFFFF && !cnt_wr, match, cap_fall};
  assign cmp_out  = out_q;
  assign irq      = |(flags & ien);

  always_comb begin
    case (bus_addr[2:1])
      2'd0:    hi_sel = cnt[15:8];
      2'd1:    hi_sel = cap[15:8];
      2'd2:    hi_sel = cmp_a[15:8];
      default: hi_sel = cmp_b[15:8];
    endcase
  end

  always_comb begin
    case (bus_addr)
      4'd0:                   bus_rdata = cnt[7:0];
      4'd2:                   bus_rdata = cap[7:0];
      4'd4:                   bus_rdata = cmp_a[7:0];
      4'd6:                   bus_rdata = cmp_b[7:0];
      4'd1, 4'd3, 4'd5, 4'd7: bus_rdata = tmp;
      4'd8:                   bus_rdata = {4'b0000, flags};
      4'd9:                   bus_rdata = {4'b0000, ien};
      4'd10:                  bus_rdata = {6'b000000, out_q};
      default:                bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], cap_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_wr) cnt <= {tmp, bus_wdata};
    else             cnt <= cnt + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap <= '0;
    else if (cap_fall) cap <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
    end else if (bus_wr && bus_addr == 4'd4) begin
      cmp_a <= {tmp, bus_wdata};
    end else if (bus_wr && bus_addr == 4'd6) begin
      cmp_b <= {tmp, bus_wdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tmp <= '0;
    else if (hi_wr) tmp <= bus_wdata;
    else if (lo_rd) tmp <= hi_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ien   <= '0;
      out_q <= '0;
    end else begin
      flags <= (flags & ~w1c) | flag_set;
      out_q <= (out_q | match) & ~clr;
      if (bus_wr && bus_addr == 4'd9) ien <= bus_wdata[3:0];
    end
  end

endmodule

// File: rtl/paddle_timer_chk.sv
module paddle_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cnt,
  input logic [15:0] cap,
  input logic [7:0]  tmp,
  input logic [7:0]  bus_wdata,
  input logic        cnt_wr,
  input logic        cap_fall,
  input logic [1:0]  match,
  input logic [1:0]  clr,
  input logic [1:0]  cmp_out,
  input logic [3:0]  flags
);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(cnt_wr) |-> cnt == $past(cnt) + 16'd1);

  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(cnt_wr) && $past(cnt) == 16'hFFFF |-> flags[3]);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cnt_wr) |-> cnt == {$past(tmp), $past(bus_wdata)});

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cap_fall) |-> cap == $past(cnt) && flags[0]);

  p_match_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(match[0]) && !$past(clr[0]) |-> cmp_out[0]);

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cmp_out & $past(clr)) == 2'b00);

endmodule

bind paddle_timer paddle_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cap(cap), .tmp(tmp),
  .bus_wdata(bus_wdata), .cnt_wr(cnt_wr), .cap_fall(cap_fall),
  .match(match), .clr(clr), .cmp_out(cmp_out), .flags(flags)
);

// File: tb/paddle_timer_bench.sv
module paddle_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, cap_in = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [1:0] cmp_out;
  logic irq;

  always #4 clk = ~clk;

  paddle_timer u_paddle_timer (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_out(cmp_out), .irq(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_cap, m_cmp[2], m_tmp, m_flags, m_en, m_out;
  bit hist[$] = '{1'b1, 1'b1, 1'b1};

  function automatic int m_hi(int a);
    case (a / 2)
      0: return m_cnt / 256;
      1: return m_cap / 256;
      2: return m_cmp[0] / 256;
      default: return m_cmp[1] / 256;
    endcase
  endfunction

  function automatic int m_rd(int a);
    case (a)
      0: return m_cnt % 256;
      2: return m_cap % 256;
      4: return m_cmp[0] % 256;
      6: return m_cmp[1] % 256;
      1, 3, 5, 7: return m_tmp;
      8: return m_flags;
      9: return m_en;
      10: return m_out;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_cmp[0] = 0; m_cmp[1] = 0; m_tmp = 0;
      m_flags = 0; m_en = 0; m_out = 0;
      hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      int a, d, setv, clrb, ncnt, ntmp;
      bit fall, wr_cnt;
      a = int'(bus_addr); d = int'(bus_wdata);
      fall = hist[2] && !hist[1];
      wr_cnt = bus_wr && a == 0;
      setv = (fall ? 1 : 0) | ((m_cnt == m_cmp[0]) ? 2 : 0) | ((m_cnt == m_cmp[1]) ? 4 : 0)
           | ((m_cnt == 65535 && !wr_cnt) ? 8 : 0);
      clrb = (bus_wr && a == 10) ? (d & 3) : 0;
      m_out = ((m_out | ((setv >> 1) & 3)) & ~clrb) & 3;
      m_flags = ((m_flags & ~((bus_wr && a == 8) ? (d & 15) : 0)) | setv) & 15;
      if (fall) m_cap = m_cnt;
      ncnt = wr_cnt ? m_tmp * 256 + d : (m_cnt + 1) % 65536;
      if (bus_wr && a == 4) m_cmp[0] = m_tmp * 256 + d;
      if (bus_wr && a == 6) m_cmp[1] = m_tmp * 256 + d;
      if (bus_wr && a == 9) m_en = d & 15;
      ntmp = m_tmp;
      if (bus_wr && a < 8 && a % 2 == 1) ntmp = d;
      else if (bus_rd && a < 8 && a % 2 == 0) ntmp = m_hi(a);
      m_tmp = ntmp;
      m_cnt = ncnt;
      hist.push_front(cap_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk_eq("R6 bus_rdata vs model", int'(bus_rdata), m_rd(int'(bus_addr)));
      chk_eq("R7 cmp_out vs model", int'(cmp_out), m_out);
      chk_eq("R10 irq vs model", int'(irq), ((m_flags & m_en) != 0) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk);
    d = int'(bus_rdata);
    #1;
    bus_rd = 1'b0;
  endtask

  task automatic rd16(int a, output int v);
    int lo, hi;
    rd(a, lo);
    rd(a + 1, hi);
    v = hi * 256 + lo;
  endtask

  task automatic wr16(int a, int v);
    wr(a + 1, (v / 256) % 256);
    wr(a, v % 256);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int v, w, c, prev;
    #1;
    // R1: reset state observed while reset is held
    idle(2);
    rd(8, v);  chk_eq("R1 flags in reset", v, 0);
    rd(9, v);  chk_eq("R1 enables in reset", v, 0);
    rd(10, v); chk_eq("R1 outputs in reset", v, 0);
    rd(0, v);  chk_eq("R1 count in reset", v, 0);
    rd(2, v);  chk_eq("R1 capture in reset", v, 0);
    chk_eq("R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    idle(3);

    // R2: free-running count
    rd16(0, v); rd16(0, w);
    chk_eq("R2 count step over two reads", (w - v + 65536) % 65536, 2);

    // R3: load counter, then wrap
    wr16(0, 16'hFFF0);
    rd16(0, v);
    chk_eq("R3 counter load", v, 16'hFFF1);
    wr(9, 8);
    idle(20);
    rd(8, v);
    chk_eq("R2 overflow flag plus zero matches", v, 4'hE);
    chk_eq("R10 irq on enabled overflow", int'(irq), 1);
    // R9: clear only the overflow flag
    wr(8, 8);
    rd(8, v);
    chk_eq("R9 write-one clears only bit 3", v, 4'h6);
    chk_eq("R10 irq drops with flag", int'(irq), 0);
    wr(10, 3);
    rd(10, v);
    chk_eq("R8 software clear of both outputs", v, 0);

    // R4: capture in step with a counter read
    wr(8, 15);
    cap_in = 1'b0;
    rd16(0, v);
    rd16(2, c);
    rd16(0, w);
    chk_eq("R4 capture value", c, (v + 1) % 65536);
    chk_eq("R4 counter keeps running", (w - c + 65536) % 65536, 3);
    rd(8, w);
    chk_eq("R4 capture flag", w & 1, 1);
    // R6: shared temporary byte
    rd(2, v);
    rd(5, w);
    chk_eq("R6 odd address returns latched high byte", w, c / 256);

    // R5: period from successive captures
    cap_in = 1'b1;
    idle(6);
    prev = -1;
    for (int i = 0; i < 4; i++) begin
      cap_in = 1'b0;
      idle(8);
      cap_in = 1'b1;
      rd16(2, c);
      idle(700 - 10);
      if (prev >= 0) chk_eq("R5 capture spacing", (c - prev + 65536) % 65536, 700);
      prev = c;
    end

    // R7: compare ahead of the counter
    wr16(0, 16'h0100);
    wr16(4, 16'h0120);
    wr(8, 15);
    wr(10, 3);
    idle(40);
    chk_eq("R7 output A high after match", int'(cmp_out[0]), 1);
    rd(8, v);
    chk_eq("R7 compare A flag", (v >> 1) & 1, 1);
    // R7: compare value already passed
    wr16(4, 16'h0100);
    wr(8, 2);
    wr(10, 1);
    idle(60);
    chk_eq("R7 passed value no output", int'(cmp_out[0]), 0);
    rd(8, v);
    chk_eq("R7 passed value no flag", (v >> 1) & 1, 0);

    // R8: clear on the match cycle
    wr16(6, 16'h0302);
    wr(10, 2);
    wr(8, 4);
    wr16(0, 16'h0300);
    idle(2);
    wr(10, 2);
    rd(10, v);
    chk_eq("R8 clear beats match", (v >> 1) & 1, 0);
    rd(8, v);
    chk_eq("R8 match B still flagged", (v >> 2) & 1, 1);

    // R10: capture-only enable
    wr(8, 15);
    wr(9, 1);
    cap_in = 1'b0;
    idle(5);
    chk_eq("R10 irq from capture", int'(irq), 1);
    cap_in = 1'b1;
    wr(8, 1);
    idle(1);
    chk_eq("R10 irq after flag clear", int'(irq), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule